// File: doc/BRIEF.md
# Flash Programming Mode Controller

This block is the parallel programming front end of an on-chip flash array. An external programmer presents a mode code, an address and a data byte, then raises a strobe. The controller acts once per strobe rising edge: it can capture a byte into a page buffer, copy the buffered bytes into the array, program or read a security byte, erase the whole array, or return array contents and fixed identification bytes.

Program and erase access is closed after reset. It opens only after an unlock handshake: two strobe pulses in unlock mode, the first carrying 55h and the second AAh, each held high for a minimum number of clocks. A lock command closes access again. The security byte uses inverted sense (1 erased, 0 programmed). Its top bit freezes the lower bits once programmed, and only a chip erase returns it to FFh. Read results leave on a valid/ready output. A result stays presented, unchanged, until the consumer takes it with `rd_ready_i`. A read strobe that arrives while an earlier result is still waiting is dropped. The array itself sits outside the block, behind a simple write/clear/read port.

Top module: `flash_prog_ctl`

## Requirements
- R1: The block acts only on a rising edge of `stb_i`, decoding `mode_i` as 1 lock, 2 unlock, 3 page load, 4 page write, 5 code read, 6 security program, 7 security read, 8 chip erase, 9 signature read. After reset it is locked, `busy_o`, `done_o`, `hs_err_o` and `rd_valid_o` are low, and the security byte reads FFh.
- R2: Access opens once two strobe pulses in mode 2 have been seen in order: the first carrying 55h, the second AAh. Each pulse must have `stb_i` sampled high on at least MIN_HIGH (default 25) clock edges. `din_i` is captured at the rising edge, and `unlocked_o` rises after the falling edge of the second pulse.
- R3: A wrong byte at either handshake step restarts the handshake from its first step and sets the sticky `hs_err_o`, which only reset clears.
- R4: A handshake pulse sampled high on fewer than MIN_HIGH edges restarts the handshake and sets `hs_err_o`.
- R5: A strobe in mode 1 clears `unlocked_o`. While locked, page load, page write, security program and chip erase have no effect, and `busy_o` stays low.
- R6: A page-load strobe stores `din_i` in buffer slot `addr_i[6:0]` and marks that slot filled.
- R7: A page-write strobe with at least one filled slot holds `busy_o` high for PAGE_BYTES cycles. During that time it writes each filled slot to array address {`addr_i[AW-1:7]`, slot} and leaves every other address alone. It then empties the buffer and raises `done_o` for exactly one clock. A page write with an empty buffer is ignored.
- R8: A security-program strobe with byte d turns the security byte s into s AND d. Once bit 7 of s is 0, the byte no longer changes.
- R9: A chip erase pulses `mem_clr_o` for one clock so that the whole array reads FFh, sets the security byte to FFh, and empties the page buffer.
- R10: Security byte bit 0 at 0 blocks page writes. Bit 1 at 0 makes code reads return FFh.
- R11: Signature read returns SIG0, SIG1, SIG2, SIG3 (defaults A5h, 3Ch, 96h, 0Fh) for `addr_i[7:0]` equal to 30h, 31h, 60h, 61h, and FFh for any other address.
- R12: A read result stays on `rd_data_o` with `rd_valid_o` high until `rd_ready_i` is seen high. A read strobe that arrives while a result is held and `rd_ready_i` is low is dropped.
- R13: Every strobe that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Selected programming mode |
| stb_i | input | 1 | Command strobe; acts on its rising edge |
| addr_i | input | AW | Address bus |
| din_i | input | 8 | Data bus |
| busy_o | output | 1 | Page write in progress |
| done_o | output | 1 | One-clock pulse at the end of a page write |
| unlocked_o | output | 1 | Program and erase access open |
| hs_err_o | output | 1 | Sticky handshake error |
| mem_we_o | output | 1 | Array byte write enable |
| mem_clr_o | output | 1 | Array erase pulse |
| mem_addr_o | output | AW | Array address |
| mem_wdata_o | output | 8 | Array write data |
| mem_rdata_i | input | 8 | Array read data for `mem_addr_o`, combinational |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 8 | Read result |
| rd_ready_i | input | 1 | Consumer accepts the read result |

## Verification
A handshake state stuck at the wrong step shows up on `unlocked_o` right after the falling edge of the second unlock pulse, or as a `hs_err_o` that is wrongly set or missing. Stale or missing page-buffer valid bits appear within one page write, as a wrong `busy_o` response or as array bytes that do or do not change. A wrong security byte shows on the next security read, and in whether later writes and code reads are blocked. A broken write walker shows as a wrong busy length or a misplaced done pulse, and is caught by the exact cycle count.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [3:0] {
    MD_IDLE   = 4'd0,
    MD_LOCK   = 4'd1,
    MD_UNLOCK = 4'd2,
    MD_LOAD   = 4'd3,
    MD_WRITE  = 4'd4,
    MD_READ   = 4'd5,
    MD_SECPRG = 4'd6,
    MD_SECRD  = 4'd7,
    MD_ERASE  = 4'd8,
    MD_SIG    = 4'd9
  } fpc_mode_e;

  typedef enum logic [1:0] {
    HS_WAIT1 = 2'd0,
    HS_HOLD1 = 2'd1,
    HS_WAIT2 = 2'd2,
    HS_HOLD2 = 2'd3
  } fpc_hs_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/fpc_strobe.sv
module fpc_strobe #(
  parameter int MIN_HIGH = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic rise_o,
  output logic fall_o,
  output logic wide_o
);
  localparam int CW = $clog2(MIN_HIGH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MIN_HIGH);

  logic          stb_q;
  logic [CW-1:0] width_q;

  assign rise_o = stb_i & ~stb_q;
  assign fall_o = ~stb_i & stb_q;
  assign wide_o = (width_q >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      width_q <= '0;
    end else begin
      stb_q <= stb_i;
      if (rise_o)
        width_q <= CW'(1);
      else if (stb_i && !wide_o)
        width_q <= width_q + CW'(1);
    end
  end
endmodule

// File: rtl/fpc_unlock.sv
module fpc_unlock
  import fpc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       wide_i,
  input  logic       sel_i,
  input  logic       lock_i,
  input  logic [7:0] din_i,
  output logic       unlocked_o,
  output logic       err_o
);
  fpc_hs_e st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= HS_WAIT1;
      unlocked_o <= 1'b0;
      err_o      <= 1'b0;
    end else if (lock_i) begin
      st_q       <= HS_WAIT1;
      unlocked_o <= 1'b0;
    end else if (rise_i) begin
      if (!sel_i) begin
        st_q <= HS_WAIT1;
      end else begin
        case (st_q)
          HS_WAIT1: begin
            if (din_i == KEY_FIRST) st_q <= HS_HOLD1;
            else err_o <= 1'b1;
          end
          HS_WAIT2: begin
            if (din_i == KEY_SECOND) st_q <= HS_HOLD2;
            else begin
              err_o <= 1'b1;
              st_q  <= HS_WAIT1;
            end
          end
          default: st_q <= HS_WAIT1;
        endcase
      end
    end else if (fall_i) begin
      case (st_q)
        HS_HOLD1: begin
          if (wide_i) st_q <= HS_WAIT2;
          else begin
            err_o <= 1'b1;
            st_q  <= HS_WAIT1;
          end
        end
        HS_HOLD2: begin
          st_q <= HS_WAIT1;
          if (wide_i) unlocked_o <= 1'b1;
          else err_o <= 1'b1;
        end
        default: st_q <= st_q;
      endcase
    end
  end
endmodule

// File: rtl/fpc_page.sv
module fpc_page #(
  parameter int PAGE_BYTES = 128,
  parameter int AW         = 16,
  localparam int PW        = $clog2(PAGE_BYTES),
  localparam int HW        = AW - PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          wr_req_i,
  input  logic          clr_i,
  input  logic [PW-1:0] slot_i,
  input  logic [HW-1:0] page_i,
  input  logic [7:0]    din_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o
);
  localparam logic [PW-1:0] LAST = PW'(PAGE_BYTES - 1);

  logic [7:0]            pg_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pg_vld;
  logic [PW-1:0]         ptr_q;
  logic [HW-1:0]         page_q;
  logic                  start;

  assign start   = wr_req_i & ~busy_o & (|pg_vld);
  assign we_o    = busy_o & pg_vld[ptr_q];
  assign addr_o  = {page_q, ptr_q};
  assign wdata_o = pg_data[ptr_q];

  always_ff @(posedge clk) begin
    if (load_i) pg_data[slot_i] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_vld <= '0;
      ptr_q  <= '0;
      page_q <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i)       pg_vld <= '0;
      else if (load_i) pg_vld[slot_i] <= 1'b1;
      if (start) begin
        busy_o <= 1'b1;
        ptr_q  <= '0;
        page_q <= page_i;
      end else if (busy_o) begin
        if (ptr_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          pg_vld <= '0;
        end else begin
          ptr_q <= ptr_q + PW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl
  import fpc_pkg::*;
#(
  parameter int         AW         = 16,
  parameter int         PAGE_BYTES = 128,
  parameter int         MIN_HIGH   = 25,
  parameter logic [7:0] SIG0       = 8'hA5,
  parameter logic [7:0] SIG1       = 8'h3C,
  parameter logic [7:0] SIG2       = 8'h96,
  parameter logic [7:0] SIG3       = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode_i,
  input  logic          stb_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    din_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          unlocked_o,
  output logic          hs_err_o,
  output logic          mem_we_o,
  output logic          mem_clr_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          rd_valid_o,
  output logic [7:0]    rd_data_o,
  input  logic          rd_ready_i
);
  localparam int PW = $clog2(PAGE_BYTES);

  fpc_mode_e     md;
  logic          rise, fall, wide, rise_g, cmd_ok;
  logic          load_en, wr_req, erase, secprg, rd_take;
  logic [7:0]    sec_q, rd_next;
  logic [AW-1:0] wr_addr;

  assign md      = fpc_mode_e'(mode_i);
  assign rise_g  = rise & ~busy_o;
  assign cmd_ok  = rise_g & unlocked_o;
  assign load_en = cmd_ok & (md == MD_LOAD);
  assign wr_req  = cmd_ok & (md == MD_WRITE) & sec_q[0];
  assign erase   = cmd_ok & (md == MD_ERASE);
  assign secprg  = cmd_ok & (md == MD_SECPRG);
  assign rd_take = rise_g & (md == MD_READ || md == MD_SECRD || md == MD_SIG)
                 & (~rd_valid_o | rd_ready_i);
  assign mem_addr_o = busy_o ? wr_addr : addr_i;

  fpc_strobe #(.MIN_HIGH(MIN_HIGH)) u_stb (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i),
    .rise_o(rise), .fall_o(fall), .wide_o(wide)
  );

  fpc_unlock u_key (
    .clk(clk), .rst_n(rst_n), .rise_i(rise_g), .fall_i(fall), .wide_i(wide),
    .sel_i(md == MD_UNLOCK), .lock_i(rise_g & (md == MD_LOCK)), .din_i(din_i),
    .unlocked_o(unlocked_o), .err_o(hs_err_o)
  );

  fpc_page #(.PAGE_BYTES(PAGE_BYTES), .AW(AW)) u_page (
    .clk(clk), .rst_n(rst_n), .load_i(load_en), .wr_req_i(wr_req), .clr_i(erase),
    .slot_i(addr_i[PW-1:0]), .page_i(addr_i[AW-1:PW]), .din_i(din_i),
    .busy_o(busy_o), .done_o(done_o), .we_o(mem_we_o),
    .addr_o(wr_addr), .wdata_o(mem_wdata_o)
  );

  always_comb begin
    rd_next = 8'hFF;
    case (md)
      MD_READ:  rd_next = sec_q[1] ? mem_rdata_i : 8'hFF;
      MD_SECRD: rd_next = sec_q;
      MD_SIG: begin
        case (addr_i[7:0])
          8'h30:   rd_next = SIG0;
          8'h31:   rd_next = SIG1;
          8'h60:   rd_next = SIG2;
          8'h61:   rd_next = SIG3;
          default: rd_next = 8'hFF;
        endcase
      end
      default: rd_next = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q      <= 8'hFF;
      mem_clr_o  <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= 8'h00;
    end else begin
      mem_clr_o <= erase;
      if (erase)
        sec_q <= 8'hFF;
      else if (secprg && sec_q[7])
        sec_q <= sec_q & din_i;
      if (rd_take) begin
        rd_valid_o <= 1'b1;
        rd_data_o  <= rd_next;
      end else if (rd_ready_i) begin
        rd_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpc_checker.sv
module fpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stb_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       unlocked_o,
  input logic       mem_we_o,
  input logic       mem_clr_o,
  input logic       rd_valid_o,
  input logic       rd_ready_i,
  input logic [7:0] rd_data_o
);
  p_we_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_busy_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(unlocked_o));

  p_clr_needs_key_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_clr_o |-> $past(unlocked_o));

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o)));

  p_open_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_o) |-> !$past(stb_i));
endmodule

bind flash_prog_ctl fpc_checker u_fpc_checker (
  .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .busy_o(busy_o), .done_o(done_o),
  .unlocked_o(unlocked_o), .mem_we_o(mem_we_o), .mem_clr_o(mem_clr_o),
  .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i), .rd_data_o(rd_data_o)
);

// File: tb/flash_prog_ctl_test.sv
`timescale 1ns/1ps
module flash_prog_ctl_test;
  localparam int AW = 10;
  localparam int MEMSZ = 1 << AW;
  localparam logic [3:0] M_LOCK = 4'd1, M_UNL = 4'd2, M_LOAD = 4'd3, M_WR = 4'd4,
    M_RD = 4'd5, M_SPRG = 4'd6, M_SRD = 4'd7, M_ERA = 4'd8, M_SIG = 4'd9;

  // signature table: {address, expected byte}
  localparam logic [17:0] SIG_TAB [6] = '{
    {10'h030, 8'hA5}, {10'h031, 8'h3C}, {10'h060, 8'h96},
    {10'h061, 8'h0F}, {10'h032, 8'hFF}, {10'h000, 8'hFF}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] mode_i = 4'd0;
  logic stb_i = 1'b0, rd_ready_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0] din_i = 8'h00;
  logic busy_o, done_o, unlocked_o, hs_err_o, mem_we_o, mem_clr_o, rd_valid_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata_i, rd_data_o;
  logic [7:0] mem [MEMSZ];
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  flash_prog_ctl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .stb_i(stb_i), .addr_i(addr_i),
    .din_i(din_i), .busy_o(busy_o), .done_o(done_o), .unlocked_o(unlocked_o),
    .hs_err_o(hs_err_o), .mem_we_o(mem_we_o), .mem_clr_o(mem_clr_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ready_i(rd_ready_i)
  );

  assign mem_rdata_i = mem[mem_addr_o];

  always @(posedge clk) begin
    if (mem_clr_o) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= 8'hFF;
    end else if (mem_we_o) begin
      mem[mem_addr_o] <= mem_wdata_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [3:0] m, input logic [AW-1:0] a,
                        input logic [7:0] d, input int hi);
    @(negedge clk);
    mode_i = m; addr_i = a; din_i = d; stb_i = 1'b1;
    repeat (hi) @(negedge clk);
    stb_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic take;
    rd_ready_i = 1'b1;
    @(negedge clk);
    rd_ready_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] m, input logic [AW-1:0] a, output logic [7:0] d);
    strobe(m, a, 8'h00, 1);
    d = rd_valid_o ? rd_data_o : 8'hXX;
    take();
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic open_key;
    strobe(M_UNL, '0, 8'h55, 25);
    strobe(M_UNL, '0, 8'hAA, 25);
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    logic saw_done;
    for (int i = 0; i < MEMSZ; i++) mem[i] = 8'(i) ^ 8'h5A;
    do_reset();

    // R1 reset state
    chk("R1 unlocked", unlocked_o, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 err", hs_err_o, 0);
    chk("R1 rd_valid", rd_valid_o, 0);
    rd(M_SRD, '0, d);
    chk("R1 security byte", d, 8'hFF);

    // R11 signature table
    foreach (SIG_TAB[k]) begin
      rd(M_SIG, SIG_TAB[k][17:8], d);
      chk("R11 signature", d, SIG_TAB[k][7:0]);
    end

    // R12 held result, second read dropped
    strobe(M_SIG, 10'h030, 8'h00, 1);
    strobe(M_SIG, 10'h031, 8'h00, 1);
    chk("R12 valid held", rd_valid_o, 1);
    chk("R12 data held", rd_data_o, 8'hA5);
    take();
    chk("R12 valid cleared", rd_valid_o, 0);

    // R5 locked commands have no effect
    strobe(M_LOAD, 10'h105, 8'h99, 1);
    strobe(M_WR, 10'h100, 8'h00, 1);
    chk("R5 busy while locked", busy_o, 0);
    strobe(M_SPRG, '0, 8'h00, 1);
    rd(M_SRD, '0, d);
    chk("R5 sec unchanged while locked", d, 8'hFF);
    strobe(M_ERA, '0, 8'h00, 1);
    rd(M_RD, 10'h105, d);
    chk("R5 erase ignored while locked", d, 8'h05 ^ 8'h5A);

    // R4 short pulse
    strobe(M_UNL, '0, 8'h55, 24);
    chk("R4 err on short pulse", hs_err_o, 1);
    strobe(M_UNL, '0, 8'hAA, 25);
    chk("R4 restart keeps locked", unlocked_o, 0);

    // R3 wrong byte
    do_reset();
    strobe(M_UNL, '0, 8'h33, 25);
    chk("R3 err on wrong byte", hs_err_o, 1);
    strobe(M_UNL, '0, 8'h55, 25);
    strobe(M_UNL, '0, 8'h5A, 25);
    chk("R3 wrong second byte locked", unlocked_o, 0);

    // R2 good handshake
    strobe(M_UNL, '0, 8'h55, 25);
    chk("R2 not open after first pulse", unlocked_o, 0);
    strobe(M_UNL, '0, 8'hAA, 25);
    chk("R2 open after second pulse", unlocked_o, 1);
    chk("R3 err sticky", hs_err_o, 1);

    // R7 write with empty buffer ignored (locked load earlier left nothing)
    strobe(M_WR, 10'h100, 8'h00, 1);
    chk("R7 empty write ignored", busy_o, 0);

    // R6 and R7 load and write a page
    strobe(M_LOAD, 10'h100, 8'h11, 1);
    strobe(M_LOAD, 10'h105, 8'h22, 1);
    strobe(M_LOAD, 10'h17F, 8'h33, 1);
    @(negedge clk);
    mode_i = M_WR; addr_i = 10'h100; stb_i = 1'b1;
    @(negedge clk);
    stb_i = 1'b0;
    n = 0; saw_done = 1'b0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk("R7 busy length", n, 128);
    chk("R7 done pulse", done_o, 1);
    @(negedge clk);
    chk("R7 done one clock", done_o, 0);
    chk("R7 slot 0 written", mem[10'h100], 8'h11);
    chk("R6 slot 5 written", mem[10'h105], 8'h22);
    chk("R7 slot 127 written", mem[10'h17F], 8'h33);
    chk("R7 empty slot untouched", mem[10'h101], 8'h01 ^ 8'h5A);
    rd(M_RD, 10'h105, d);
    chk("R6 code read back", d, 8'h22);
    strobe(M_WR, 10'h100, 8'h00, 1);
    chk("R7 buffer emptied", busy_o, 0);

    // R13 strobe during busy ignored
    strobe(M_LOAD, 10'h201, 8'h77, 1);
    @(negedge clk);
    mode_i = M_WR; addr_i = 10'h200; stb_i = 1'b1;
    @(negedge clk);
    stb_i = 1'b0;
    strobe(M_SPRG, '0, 8'h00, 1);
    wait_idle();
    rd(M_SRD, '0, d);
    chk("R13 sec prog ignored while busy", d, 8'hFF);
    chk("R13 write completed", mem[10'h201], 8'h77);

    // R8 and R10 security byte
    strobe(M_SPRG, '0, 8'hFE, 1);
    rd(M_SRD, '0, d);
    chk("R8 program bit 0", d, 8'hFE);
    strobe(M_LOAD, 10'h300, 8'h44, 1);
    strobe(M_WR, 10'h300, 8'h00, 1);
    chk("R10 write blocked", busy_o, 0);
    chk("R10 array untouched", mem[10'h300], 8'h00 ^ 8'h5A);
    strobe(M_SPRG, '0, 8'hFD, 1);
    rd(M_RD, 10'h105, d);
    chk("R10 read protected", d, 8'hFF);
    strobe(M_SPRG, '0, 8'h7F, 1);
    rd(M_SRD, '0, d);
    chk("R8 program bit 7", d, 8'h7C);
    strobe(M_SPRG, '0, 8'h00, 1);
    rd(M_SRD, '0, d);
    chk("R8 frozen by bit 7", d, 8'h7C);

    // R9 chip erase
    strobe(M_ERA, '0, 8'h00, 1);
    rd(M_SRD, '0, d);
    chk("R9 sec erased", d, 8'hFF);
    rd(M_RD, 10'h105, d);
    chk("R9 array erased", d, 8'hFF);
    strobe(M_WR, 10'h300, 8'h00, 1);
    chk("R9 buffer emptied", busy_o, 0);

    // R5 lock command
    strobe(M_LOCK, '0, 8'h00, 1);
    chk("R5 lock clears access", unlocked_o, 0);
    strobe(M_LOAD, 10'h010, 8'h12, 1);
    strobe(M_WR, 10'h000, 8'h00, 1);
    chk("R5 write after lock", busy_o, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule